// File: doc/BRIEF.md
# Two-Bit Burst Address Generator

This block produces the address sequence for a four-beat synchronous memory burst. On a cycle where the chip is enabled and either the processor strobe or the controller strobe is high, it captures the full external address. That address is the first beat of a new burst. After the load, each cycle with the advance input high moves the two least significant address bits to the next beat. The upper bits stay frozen until the next load.

Two step orders are available. In linear order the low bits count upward modulo four from the start value. In interleaved order the low bits are the start value XORed with a beat count running from 0 to 3. The order input is sampled together with the address at load time, so one burst always keeps one order. A load may happen on every cycle, so single accesses can follow each other with no idle cycles. The burst counter never carries into the upper bits.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `addr_out` is all zeros.
- R2: When `chip_en` and `strobe_cpu` are both high at a rising edge, `addr_out` equals the `addr_in` sampled at that edge, starting in the next cycle.
- R3: When `chip_en` and `strobe_ctl` are both high at a rising edge, `addr_out` equals the `addr_in` sampled at that edge, starting in the next cycle.
- R4: When `chip_en` is low, both strobes are ignored: with `adv` low, `addr_out` keeps its value whatever `addr_in` and the strobes do.
- R5: With no load and `adv` low, `addr_out` holds its value.
- R6: If `lin_mode` was 1 at load, each advance sets the low two bits of `addr_out` to (previous low bits + 1) mod 4. For example, start 1 gives 1,2,3,0.
- R7: If `lin_mode` was 0 at load, after k advances the low two bits equal start XOR (k mod 4). For example, start 1 gives 1,0,3,2.
- R8: Advancing past the fourth beat wraps to the first beat of the same sequence. Bits above bit 1 never change without a load, and there is no carry from the low bits.
- R9: A load that coincides with `adv` high takes priority: the next `addr_out` is the new `addr_in` exactly.
- R10: The order is fixed at load time. A change of `lin_mode` during a burst has no effect until the next load.
- R11: Loads on consecutive cycles each appear on `addr_out` one cycle later, with no cycles lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_in | input | ADDR_W | External start address |
| strobe_cpu | input | 1 | Processor address strobe, loads `addr_in` |
| strobe_ctl | input | 1 | Controller address strobe, loads `addr_in` |
| adv | input | 1 | Step the burst to the next beat |
| chip_en | input | 1 | Enables both strobes |
| lin_mode | input | 1 | 1 = linear order, 0 = interleaved order, sampled at load |
| addr_out | output | ADDR_W | Current burst address |

## Verification
A load and an advance can fall in the same cycle, and the load must win. The bench provokes this by raising a strobe together with `adv` in the middle of a burst. It then checks that the next address is the new external address exactly, rather than the old burst stepped or the new address stepped. A second overlap happens when `lin_mode` changes in the same cycle as an advance. Here the bench checks that the step still follows the order captured at the earlier load.

// File: rtl/burst_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the burst address generator.
// Assumes a power-of-two burst length given by BEAT_W_DEF counter bits.
package burst_pkg;
    localparam int BEAT_W_DEF = 2;
    localparam int ADDR_W_DEF = 20;

    // Step order captured at load time.
    typedef enum logic {
        ORD_XOR = 1'b0,
        ORD_LIN = 1'b1
    } order_e;
endpackage

// File: rtl/burst_strobe_dec.sv
`timescale 1ns/1ps
// Module: burst_strobe_dec
// Decides each cycle whether to load a new start address or step the
// burst. Assumes all inputs are synchronous to the clock that samples the
// outputs. A load always masks a step in the same cycle.
module burst_strobe_dec (
    input  logic strobe_cpu,
    input  logic strobe_ctl,
    input  logic chip_en,
    input  logic adv,
    output logic load,
    output logic step
);
    logic any_strobe;

    // Purpose: merge the two strobes, qualify with enable, give load priority.
    always_comb begin
        any_strobe = strobe_cpu | strobe_ctl;
        load       = chip_en & any_strobe;
        step       = adv & ~load;
    end
endmodule

// File: rtl/burst_order_map.sv
`timescale 1ns/1ps
// Module: burst_order_map
// Maps start value and beat count to the low address bits in the chosen
// order. Purely combinational. Assumes the beat count wraps at 2**BEAT_W.
module burst_order_map #(
    parameter int BEAT_W = burst_pkg::BEAT_W_DEF
) (
    input  logic [BEAT_W-1:0] start_low,
    input  logic [BEAT_W-1:0] beat,
    input  burst_pkg::order_e order,
    output logic [BEAT_W-1:0] low_out
);
    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] xor_low;

    // Per-bit XOR form of the interleaved order.
    for (genvar i = 0; i < BEAT_W; i++) begin : g_xor
        assign xor_low[i] = start_low[i] ^ beat[i];
    end

    // Purpose: modulo addition for linear order, then select by order.
    always_comb begin
        lin_low = start_low + beat;
        low_out = (order == burst_pkg::ORD_LIN) ? lin_low : xor_low;
    end
endmodule

// File: rtl/burst_state_reg.sv
`timescale 1ns/1ps
// Module: burst_state_reg
// Holds the upper address, the start low bits, the beat count and the
// captured order. Assumes load and step are never both high (decoder
// guarantees). Synchronous active-low reset clears everything.
module burst_state_reg #(
    parameter int ADDR_W = burst_pkg::ADDR_W_DEF,
    parameter int BEAT_W = burst_pkg::BEAT_W_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic                     step,
    input  logic [ADDR_W-1:0]        addr_in,
    input  logic                     lin_mode,
    output logic [ADDR_W-BEAT_W-1:0] upper_q,
    output logic [BEAT_W-1:0]        start_q,
    output logic [BEAT_W-1:0]        beat_q,
    output burst_pkg::order_e        order_q
);
    localparam int UP_W = ADDR_W - BEAT_W;

    // Purpose: capture the address and order on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
            order_q <= burst_pkg::ORD_XOR;
        end else if (load) begin
            upper_q <= addr_in[ADDR_W-1:BEAT_W];
            start_q <= addr_in[BEAT_W-1:0];
            order_q <= lin_mode ? burst_pkg::ORD_LIN : burst_pkg::ORD_XOR;
        end
    end

    // Purpose: clear the beat count on load and wrap it on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (load) begin
            beat_q <= '0;
        end else if (step) begin
            beat_q <= beat_q + BEAT_W'(1);
        end
    end

    // Width sanity: the upper part must have at least one bit.
    if (UP_W < 1) begin : g_bad_width
        initial $error("burst_state_reg: ADDR_W must exceed BEAT_W");
    end
endmodule

// File: rtl/burst_addr_gen.sv
`timescale 1ns/1ps
// Module: burst_addr_gen (top)
// Generates burst addresses: loads on either strobe when enabled, steps the
// low BEAT_W bits on advance in linear or interleaved order, holds the
// upper bits. Assumes all inputs are synchronous to clk.
module burst_addr_gen #(
    parameter int ADDR_W = burst_pkg::ADDR_W_DEF,
    parameter int BEAT_W = burst_pkg::BEAT_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strobe_cpu,
    input  logic              strobe_ctl,
    input  logic              adv,
    input  logic              chip_en,
    input  logic              lin_mode,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int UP_W = ADDR_W - BEAT_W;

    logic              load;
    logic              step;
    logic [UP_W-1:0]   upper_q;
    logic [BEAT_W-1:0] start_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] low_now;
    burst_pkg::order_e order_q;

    burst_strobe_dec u_dec (
        .strobe_cpu (strobe_cpu),
        .strobe_ctl (strobe_ctl),
        .chip_en    (chip_en),
        .adv        (adv),
        .load       (load),
        .step       (step)
    );

    burst_state_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .addr_in  (addr_in),
        .lin_mode (lin_mode),
        .upper_q  (upper_q),
        .start_q  (start_q),
        .beat_q   (beat_q),
        .order_q  (order_q)
    );

    burst_order_map #(.BEAT_W(BEAT_W)) u_map (
        .start_low (start_q),
        .beat      (beat_q),
        .order     (order_q),
        .low_out   (low_now)
    );

    // Purpose: assemble the output address from held upper and mapped low bits.
    always_comb begin
        addr_out = {upper_q, low_now};
    end
endmodule

// File: rtl/burst_addr_gen_chk.sv
`timescale 1ns/1ps
// Module: burst_addr_gen_chk
// Property checker bound to burst_addr_gen. Observes ports plus the
// captured order flag.
module burst_addr_gen_chk #(
    parameter int ADDR_W = burst_pkg::ADDR_W_DEF,
    parameter int BEAT_W = burst_pkg::BEAT_W_DEF
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic              strobe_cpu,
    input logic              strobe_ctl,
    input logic              adv,
    input logic              chip_en,
    input logic [ADDR_W-1:0] addr_out,
    input burst_pkg::order_e order_q
);
    logic ld;
    assign ld = chip_en & (strobe_cpu | strobe_ctl);

    AST_LOAD_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && strobe_cpu) |=> addr_out == $past(addr_in)); // R2
    AST_LOAD_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && strobe_ctl) |=> addr_out == $past(addr_in)); // R3
    AST_IGNORE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_en && !adv) |=> $stable(addr_out)); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !adv) |=> $stable(addr_out)); // R5
    AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && adv && order_q == burst_pkg::ORD_LIN) |=>
        addr_out[BEAT_W-1:0] == BEAT_W'($past(addr_out[BEAT_W-1:0]) + BEAT_W'(1))); // R6
    AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(addr_out[ADDR_W-1:BEAT_W])); // R8
    AST_LOAD_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && adv) |=> addr_out == $past(addr_in)); // R9
    AST_ORDER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(order_q)); // R10
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_in    (addr_in),
    .strobe_cpu (strobe_cpu),
    .strobe_ctl (strobe_ctl),
    .adv        (adv),
    .chip_en    (chip_en),
    .addr_out   (addr_out),
    .order_q    (order_q)
);

// File: tb/tb_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_burst_addr_gen;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          strobe_cpu = 1'b0;
    logic          strobe_ctl = 1'b0;
    logic          adv = 1'b0;
    logic          chip_en = 1'b0;
    logic          lin_mode = 1'b0;
    logic [AW-1:0] addr_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl), .adv(adv),
        .chip_en(chip_en), .lin_mode(lin_mode), .addr_out(addr_out)
    );

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance one clock edge; sample 2 ns after it.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle_inputs();
        strobe_cpu = 0; strobe_ctl = 0; adv = 0; chip_en = 1;
    endtask

    task automatic load(input logic [AW-1:0] a, input logic lin, input logic use_ctl);
        addr_in = a; lin_mode = lin; chip_en = 1; adv = 0;
        strobe_cpu = !use_ctl; strobe_ctl = use_ctl;
        tick();
        idle_inputs();
    endtask

    task automatic t_reset();
        rst_n = 0; chip_en = 1; strobe_cpu = 1; addr_in = 20'hFFFFF;
        tick(); tick();
        check("R1 during reset", addr_out, '0);
        idle_inputs();
        rst_n = 1;
        tick();
        check("R1 after release", addr_out, '0);
    endtask

    task automatic t_linear();
        logic [AW-1:0] base = 20'h12345;
        load(base, 1'b1, 1'b0);
        check("R2 cpu load", addr_out, base);
        adv = 1;
        tick(); check("R6 beat1", addr_out, 20'h12346);
        tick(); check("R6 beat2", addr_out, 20'h12347);
        tick(); check("R6 R8 beat3 no carry", addr_out, 20'h12344);
        tick(); check("R8 wrap", addr_out, base);
        adv = 0;
    endtask

    task automatic t_interleave();
        logic [AW-1:0] base = 20'hABCD5;
        load(base, 1'b0, 1'b1);
        check("R3 ctl load", addr_out, base);
        adv = 1;
        tick(); check("R7 beat1", addr_out, 20'hABCD4);
        tick(); check("R7 beat2", addr_out, 20'hABCD7);
        tick(); check("R7 beat3", addr_out, 20'hABCD6);
        tick(); check("R8 xor wrap", addr_out, base);
        adv = 0;
    endtask

    task automatic t_carry();
        load(20'h7FFFF, 1'b1, 1'b0);
        adv = 1;
        tick(); check("R8 no carry upper", addr_out, 20'h7FFFC);
        adv = 0;
    endtask

    task automatic t_hold();
        load(20'h00F02, 1'b1, 1'b0);
        addr_in = 20'h55555;
        tick(); tick(); tick();
        check("R5 hold", addr_out, 20'h00F02);
    endtask

    task automatic t_disabled();
        load(20'h31111, 1'b0, 1'b0);
        chip_en = 0; strobe_cpu = 1; strobe_ctl = 1; addr_in = 20'h4AAAA;
        tick(); tick();
        check("R4 strobes ignored", addr_out, 20'h31111);
        idle_inputs();
    endtask

    task automatic t_priority();
        load(20'h20000, 1'b1, 1'b0);
        adv = 1;
        tick(); check("R6 pre-priority", addr_out, 20'h20001);
        strobe_ctl = 1; addr_in = 20'h9ABC2;
        tick(); check("R9 load wins over adv", addr_out, 20'h9ABC2);
        idle_inputs();
    endtask

    task automatic t_order_latch();
        load(20'h40001, 1'b0, 1'b0);
        lin_mode = 1; adv = 1;
        tick(); check("R10 order kept interleaved", addr_out, 20'h40000);
        tick(); check("R10 order kept beat2", addr_out, 20'h40003);
        adv = 0;
    endtask

    task automatic t_back_to_back();
        logic [AW-1:0] seq [4] = '{20'h11112, 20'h22223, 20'h33330, 20'h44441};
        chip_en = 1;
        for (int i = 0; i < 4; i++) begin
            addr_in = seq[i];
            strobe_cpu = (i % 2 == 0); strobe_ctl = (i % 2 == 1);
            tick();
            check("R11 back-to-back", addr_out, seq[i]);
        end
        idle_inputs();
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_linear();
        t_interleave();
        t_carry();
        t_hold();
        t_disabled();
        t_priority();
        t_order_latch();
        t_back_to_back();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule